// File: doc/BRIEF.md
# Key-Serviced Watchdog Timer

This block is a watchdog that counts clock cycles while it is enabled. It first divides the clock by a fixed power of two, then counts the divided ticks up to a terminal count of 2^N. N is a read-only postscaler field. Software keeps the system alive by writing a 16-bit service key into the upper halfword of the control register. That write restarts the whole count, prescaler included. If the key does not arrive before the terminal count, the block does three things on the same clock edge: it raises a reset request for exactly one cycle, it sets a sticky cause flag in a separate cause register, and it restarts the count. Counting continues for as long as the enable bit stays set.

The bus port is a plain single-cycle register port. It has a word address, a write strobe, byte enables, write data and combinational read data. The control register and the cause register each have a set alias and a clear alias. Writing a 1 through an alias changes only that bit. The postscaler, clock-select and window fields are captured from configuration inputs during reset. After that they can only be read.

Top module: `key_watchdog`

## Requirements
- R1: After reset, `wdt_rst_req` is 0. The cause register (word address 4) reads 0. The control register (word address 0) reads bit 15 = 0, bits 12:8 = `cfg_post`, bits 7:6 = `cfg_clk_sel`, bit 0 = `cfg_window`, and 0 in every other bit.
- R2: Control bit 15 is the enable. Three writes change it, and each needs byte enable 1 (`bus_be[1]`) to be set: a write to address 0 loads it from `bus_wdata[15]`; a write to address 1 with `bus_wdata[15]`=1 sets it; a write to address 2 with `bus_wdata[15]`=1 clears it. A write without `bus_be[1]` leaves it unchanged.
- R3: Counting starts at the edge that sets the enable. `wdt_rst_req` is then high for exactly one cycle, starting at the edge that completes 32·2^N enabled clock cycles. The count restarts at that edge, and the request repeats every 32·2^N enabled cycles.
- R4: A write to address 0 with byte enables exactly 4'b1100 and `bus_wdata[31:16]`=16'h5743 restarts the count, so that the next request comes 32·2^N cycles after that write. Each of the following has no effect on the timing: any other value, any other byte-enable pattern, or any other address.
- R5: While the enable is 0 the count holds its value. After re-enabling, the request comes once the remaining cycles of the period have elapsed.
- R6: Bus writes never change bits 12:8, 7:6 or 0 of the control register. Neither do changes on the configuration inputs after reset.
- R7: A timeout sets cause bit 4. The bit stays set through later timeouts. It is cleared by writing 1 to bit 4 at address 6 with `bus_be[0]` set, and set by writing 1 to bit 4 at address 5.
- R8: Cause bits 3 and 2 change only by software. Writing 1s at address 5 sets them, writing 1s at address 6 clears them, and a write to address 4 with `bus_be[0]` loads bits 4:2 directly.
- R9: If a timeout and a clear of cause bit 4 land on the same edge, the bit ends up set. If a valid service key lands on the edge that would have been the timeout, no request is made.
- R10: Any write in the cycle right after the enable falls from 1 to 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_post | input | 5 | Postscaler exponent N, captured at reset |
| cfg_clk_sel | input | 2 | Clock-select status, captured at reset |
| cfg_window | input | 1 | Window-mode status, captured at reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two events can fall on the same edge as the timeout. The first is a clear-alias write to the cause flag. The second is a service key write. The bench provokes both by timing the write so that its clock edge is exactly the 32·2^N-th enabled cycle, counted from the enable edge. For the flag clear, it judges the result by reading the flag afterwards, which must still be set. For the key, it judges by watching the request line, which must stay low on that edge and next rise one full period later. Period timing is swept across several postscaler values and checked against the cycle count computed in the bench.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int POST_W   = 5;
    localparam int CNT_W    = 2 ** POST_W;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;

    localparam logic [15:0] SERVICE_KEY = 16'h5743;

    localparam logic [ADDR_W-1:0] A_CTRL      = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_SET  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL_CLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAUSE     = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAUSE_SET = 3'd5;
    localparam logic [ADDR_W-1:0] A_CAUSE_CLR = 3'd6;

    localparam int EN_BIT    = 15;
    localparam int POST_LSB  = 8;
    localparam int CSEL_LSB  = 6;
    localparam int WIN_BIT   = 0;
    localparam int CAUSE_LSB = 2;

    typedef struct packed {
        logic wdt;
        logic sleep;
        logic idle;
    } cause_t;

    typedef struct packed {
        logic [POST_W-1:0] post;
        logic [1:0]        csel;
        logic              win;
    } cfg_t;

    function automatic logic [CNT_W-1:0] last_count(input logic [POST_W-1:0] n);
        return (CNT_W'(1) << n) - CNT_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input logic en, input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = en;
        w[POST_LSB +: POST_W] = c.post;
        w[CSEL_LSB +: 2] = c.csel;
        w[WIN_BIT] = c.win;
        return w;
    endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int LOG2 = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic [LOG2-1:0] div_q;

    assign tick = run && (&div_q);

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else if (run)       div_q <= div_q + 1'b1;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdt_period.sv
module wdt_period
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic [POST_W-1:0] post,
    output logic              expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last   = last_count(post);
    assign expire = tick && (cnt_q == last) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import kwd_pkg::*;
#(
    parameter int PRE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [POST_W-1:0] cfg_post,
    input  logic [1:0]        cfg_clk_sel,
    input  logic              cfg_window,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_req
);
    cfg_t   cfg_q;
    cause_t cause_q, cause_n;
    logic   en_q, en_n, blk_q, req_q;
    logic   acc, key_hit, lane_en, tick, expire;
    cause_t wr_bits;

    assign acc     = bus_we && !blk_q;
    assign key_hit = acc && (bus_addr == A_CTRL) && (bus_be == 4'b1100)
                     && (bus_wdata[31:16] == SERVICE_KEY);
    assign lane_en = acc && bus_be[1];
    assign wr_bits = cause_t'(bus_wdata[CAUSE_LSB +: 3]);

    always_comb begin
        en_n = en_q;
        if (lane_en) begin
            case (bus_addr)
                A_CTRL:     en_n = bus_wdata[EN_BIT];
                A_CTRL_SET: if (bus_wdata[EN_BIT]) en_n = 1'b1;
                A_CTRL_CLR: if (bus_wdata[EN_BIT]) en_n = 1'b0;
                default:    en_n = en_q;
            endcase
        end
    end

    always_comb begin
        cause_n = cause_q;
        if (acc && bus_be[0]) begin
            case (bus_addr)
                A_CAUSE:     cause_n = wr_bits;
                A_CAUSE_SET: cause_n = cause_q | wr_bits;
                A_CAUSE_CLR: cause_n = cause_q & ~wr_bits;
                default:     cause_n = cause_q;
            endcase
        end
        if (expire) cause_n.wdt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{post: cfg_post, csel: cfg_clk_sel, win: cfg_window};
            en_q    <= 1'b0;
            blk_q   <= 1'b0;
            cause_q <= '0;
            req_q   <= 1'b0;
        end else begin
            en_q    <= en_n;
            blk_q   <= en_q && !en_n;
            cause_q <= cause_n;
            req_q   <= expire;
        end
    end

    wdt_prescale #(.LOG2(PRE_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (en_q),
        .restart (key_hit),
        .tick    (tick)
    );

    wdt_period u_per (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (key_hit),
        .post    (cfg_q.post),
        .expire  (expire)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL, A_CTRL_SET, A_CTRL_CLR: bus_rdata = ctrl_word(en_q, cfg_q);
            A_CAUSE, A_CAUSE_SET, A_CAUSE_CLR:
                bus_rdata[CAUSE_LSB +: 3] = cause_q;
            default: bus_rdata = '0;
        endcase
    end

    assign wdt_rst_req = req_q;

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> !wdt_rst_req);
    // R7
    cause_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> cause_q.wdt);
    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_q));
    // R10
    blackout_chk: assert property (@(posedge clk) disable iff (rst)
        blk_q |=> $stable(en_q) && $stable(cause_q));
    // R9
    key_wins_chk: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> !wdt_rst_req);
endmodule

// File: tb/test_key_watchdog.sv
`timescale 1ns/1ps
module test_key_watchdog;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_post = '0;
    logic [1:0]  cfg_clk_sel = '0;
    logic        cfg_window = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int tests = 0, fails = 0;
    int cyc = 0, req_cnt = 0, last_req = -1, pulse_err = 0;
    logic prev_req = 1'b0;

    always #2 clk = ~clk;

    key_watchdog i_key_watchdog (
        .clk(clk), .rst(rst), .cfg_post(cfg_post), .cfg_clk_sel(cfg_clk_sel),
        .cfg_window(cfg_window), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wdt_rst_req) begin
            req_cnt++;
            last_req = cyc;
            if (prev_req) pulse_err++;
        end
        prev_req = wdt_rst_req;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_reset(input logic [4:0] n, input logic [1:0] cs, input logic w);
        @(negedge clk);
        cfg_post = n; cfg_clk_sel = cs; cfg_window = w; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
        #1;
    endtask

    initial begin
        #(100000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0, p, tk, tr, d, r, t, n0;

        // R1 reset state
        do_reset(5'd3, 2'd2, 1'b1);
        rd(3'd0, v); check("R1 ctrl", v, 32'h0000_0381);
        rd(3'd4, v); check("R1 cause", v, 32'h0);
        check("R1 req", {31'b0, wdt_rst_req}, 32'h0);

        // R2 enable paths
        wr(3'd0, 4'b0010, 32'h0000_8000); rd(3'd0, v); check("R2 base set", v[15], 1);
        wr(3'd2, 4'b0010, 32'h0000_8000); rd(3'd0, v); check("R2 clr alias", v[15], 0);
        repeat (2) @(negedge clk);
        wr(3'd1, 4'b0001, 32'h0000_8000); rd(3'd0, v); check("R2 no lane", v[15], 0);
        wr(3'd1, 4'b0010, 32'h0000_8000); rd(3'd0, v); check("R2 set alias", v[15], 1);
        wr(3'd0, 4'b0010, 32'h0000_0000); rd(3'd0, v); check("R2 base clr", v[15], 0);
        repeat (2) @(negedge clk);

        // R6 read-only fields
        wr(3'd0, 4'b1111, 32'h0000_1CFE); rd(3'd0, v); check("R6 base write", v, 32'h0000_0381);
        wr(3'd2, 4'b1111, 32'h0000_1FC1); rd(3'd0, v); check("R6 clr alias", v, 32'h0000_0381);
        cfg_post = 5'd17; cfg_clk_sel = 2'd1; cfg_window = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R6 cfg change", v, 32'h0000_0381);

        // R3 period sweep, R7 cause set
        for (int n = 0; n < 6; n++) begin
            do_reset(n[4:0], 2'd0, 1'b0);
            p = 32 << n;
            n0 = req_cnt;
            wr(3'd1, 4'b0010, 32'h0000_8000);
            t0 = cyc;
            wait_until(t0 + p - 1);
            check("R3 no early req", req_cnt, n0);
            wait_until(t0 + p + 1);
            check("R3 first req", last_req, t0 + p);
            rd(3'd4, v); check("R7 cause set", v, 32'h10);
            wait_until(t0 + 2 * p + 1);
            check("R3 repeat req", last_req, t0 + 2 * p);
            check("R3 req count", req_cnt, n0 + 2);
        end
        check("R3 pulse width", pulse_err, 0);

        // R7 sticky and aliases
        rd(3'd4, v); check("R7 survives", v, 32'h10);
        wr(3'd6, 4'b0001, 32'h08); rd(3'd4, v); check("R7 other clr", v, 32'h10);
        wr(3'd6, 4'b0001, 32'h10); rd(3'd4, v); check("R7 clr", v, 32'h0);
        wr(3'd5, 4'b0001, 32'h10); rd(3'd4, v); check("R7 set", v, 32'h10);
        wr(3'd6, 4'b0001, 32'h10);

        // R8 idle/sleep bits
        do_reset(5'd2, 2'd0, 1'b0);
        wr(3'd5, 4'b0001, 32'h0C); rd(3'd4, v); check("R8 set", v, 32'h0C);
        wr(3'd6, 4'b0001, 32'h04); rd(3'd4, v); check("R8 clr", v, 32'h08);
        wr(3'd4, 4'b0001, 32'h14); rd(3'd4, v); check("R8 base", v, 32'h14);
        wr(3'd4, 4'b0010, 32'h00); rd(3'd4, v); check("R8 no lane", v, 32'h14);
        wr(3'd4, 4'b0001, 32'h00);

        // R4 service key
        do_reset(5'd4, 2'd0, 1'b0);
        p = 512;
        n0 = req_cnt;
        wr(3'd1, 4'b0010, 32'h0000_8000);
        t0 = cyc;
        wait_until(t0 + 100);
        wr(3'd0, 4'b1100, 32'h5743_0000);
        tk = cyc;
        wait_until(t0 + p + 1);
        check("R4 key delays req", req_cnt, n0);
        wait_until(tk + p + 1);
        check("R4 req after key", last_req, tk + p);
        tr = tk + p;
        wait_until(tr + 10);
        wr(3'd0, 4'b1100, 32'h5742_0000);
        wr(3'd0, 4'b1111, 32'h5743_8000);
        wr(3'd0, 4'b0100, 32'h0043_0000);
        wr(3'd0, 4'b1000, 32'h5700_0000);
        wr(3'd1, 4'b1100, 32'h5743_0000);
        wr(3'd4, 4'b1100, 32'h5743_0000);
        wait_until(tr + p + 1);
        check("R4 bad keys ignored", last_req, tr + p);

        // R5 pause and resume
        do_reset(5'd2, 2'd0, 1'b0);
        p = 128;
        n0 = req_cnt;
        wr(3'd1, 4'b0010, 32'h0000_8000);
        t0 = cyc;
        wait_until(t0 + 49);
        wr(3'd2, 4'b0010, 32'h0000_8000);
        d = cyc;
        wait_until(d + p + 20);
        check("R5 held while off", req_cnt, n0);
        wr(3'd1, 4'b0010, 32'h0000_8000);
        r = cyc;
        wait_until(r + p - (d - t0) + 1);
        check("R5 resume remaining", last_req, r + p - (d - t0));

        // R9 collisions
        do_reset(5'd1, 2'd0, 1'b0);
        p = 64;
        wr(3'd1, 4'b0010, 32'h0000_8000);
        t0 = cyc;
        t = t0 + p;
        wait_until(t - 1);
        wr(3'd6, 4'b0001, 32'h10);
        rd(3'd4, v); check("R9 set beats clr", v, 32'h10);
        check("R9 req at collision", last_req, t);
        n0 = req_cnt;
        t = t + p;
        wait_until(t - 1);
        wr(3'd0, 4'b1100, 32'h5743_0000);
        wait_until(t + 2);
        check("R9 key beats expiry", req_cnt, n0);
        wait_until(t + p + 1);
        check("R9 req after key", last_req, t + p);

        // R10 blackout after disable
        wr(3'd2, 4'b0010, 32'h0000_8000);
        wr(3'd1, 4'b0010, 32'h0000_8000);
        rd(3'd0, v); check("R10 enable ignored", v[15], 0);
        wr(3'd6, 4'b0001, 32'h10);
        wr(3'd1, 4'b0010, 32'h0000_8000);
        wr(3'd2, 4'b0010, 32'h0000_8000);
        wr(3'd5, 4'b0001, 32'h04);
        rd(3'd4, v); check("R10 cause ignored", v, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule